// File: doc/BRIEF.md
# Spindle Spin-Up Start Mode Controller

This block decides when a disc drive's spindle motor may start turning. Two strap pins choose one of four start policies. A 7-bit slot identifier sets the stagger delay in one of them. A start-command pulse, produced by a command decoder elsewhere, releases the motor in another. A one-second tick drives the stagger timer. The straps and slot identifier are captured while reset is held and stay frozen until the next reset. Later movement on those pins therefore cannot change the chosen policy.

The outputs are a motor-enable level, which holds once raised, and a 2-bit code that reports the latched policy. In the staggered policy, drives in a shared enclosure start at different times. Each drive waits a multiple of a fixed step, and the multiplier is the slot identifier modulo 8. This spreads the start-up current surge over as much as 84 seconds.

Top module: `spinup_ctrl`

## Requirements
- R1: While `rst_n` is low, `motor_en_o` is 0. Reset is synchronous, and the block samples `strap_a_i`, `strap_b_i` and `slot_id_i` on every clock edge with `rst_n` low. The values from the last such edge are held after reset is released, and pin changes after that are ignored until the next reset.
- R2: `mode_o` reports the latched policy as the 2-bit code {strap_b, strap_a}. 2'b00 means start at once, 2'b10 means wait for a command, 2'b01 means staggered, and 2'b11 means never start. The code stays constant from the first edge after reset until the next reset.
- R3: In policy 2'b00, `motor_en_o` rises on the first clock edge with `rst_n` high.
- R4: In policy 2'b10, `motor_en_o` rises on the first edge after reset at which `start_cmd_i` is sampled high, and not before.
- R5: In policy 2'b01, let N = 12 × (slot_id[2:0]). `motor_en_o` rises on the clock edge that follows the edge at which the N-th `sec_tick_i` pulse after reset is sampled. Bits 6:3 of the slot identifier have no effect.
- R6: In policy 2'b01 with slot_id[2:0] = 0, `motor_en_o` rises on the first clock edge with `rst_n` high.
- R7: In policy 2'b01, `start_cmd_i` has no effect on when the motor starts.
- R8: In policy 2'b11, `motor_en_o` never rises, whether or not start commands or ticks arrive.
- R9: Once `motor_en_o` is 1, it stays 1 until reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; the straps are sampled while it is low |
| strap_a_i | input | 1 | Start policy strap, low-order bit of the policy code |
| strap_b_i | input | 1 | Start policy strap, high-order bit of the policy code |
| slot_id_i | input | 7 | Slot identifier; bits 2:0 set the stagger multiplier |
| start_cmd_i | input | 1 | One-cycle start-command pulse |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| motor_en_o | output | 1 | Spindle motor enable, holds once set |
| mode_o | output | 2 | Latched start policy code |

## Verification
A corrupted latched configuration shows at `mode_o` on the first edge after reset. It also shows later as a motor start that comes at the wrong time or never comes. A stagger counter that is off by one, or that counts the wrong multiplier, moves the rising edge of `motor_en_o` by at least one tick period. For that reason the bench samples the enable in the cycle just before the expected edge and again just after it. An enable that drops, or a command that leaks into the staggered or disabled policies, shows within one cycle of the event that caused it.

// File: rtl/spinup_pkg.sv
package spinup_pkg;

    localparam int unsigned SLOT_W    = 7;
    localparam int unsigned MULT_W    = 3;
    localparam int unsigned STEP_SECS = 12;
    localparam int unsigned MAX_SECS  = STEP_SECS * ((1 << MULT_W) - 1);
    localparam int unsigned SECS_W    = $clog2(MAX_SECS + 1);

    typedef enum logic [1:0] {
        POLICY_AT_ONCE   = 2'b00,
        POLICY_STAGGERED = 2'b01,
        POLICY_COMMAND   = 2'b10,
        POLICY_NEVER     = 2'b11
    } policy_e;

    typedef struct packed {
        policy_e             policy;
        logic [MULT_W-1:0]   mult;
    } spin_cfg_t;

endpackage

// File: rtl/spinup_cfg_latch.sv
module spinup_cfg_latch
    import spinup_pkg::*;
#(
    parameter int unsigned ID_W = SLOT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_a_i,
    input  logic            strap_b_i,
    input  logic [ID_W-1:0] slot_id_i,
    output spin_cfg_t       cfg_o
);

    spin_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.policy = policy_e'({strap_b_i, strap_a_i});
            cfg_d.mult   = slot_id_i[MULT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/spinup_stagger_timer.sv
module spinup_stagger_timer
    import spinup_pkg::*;
#(
    parameter int unsigned STEP = STEP_SECS,
    parameter int unsigned MW   = MULT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [MW-1:0] mult_i,
    input  logic          tick_i,
    output logic          expired_o
);

    localparam int unsigned LIMIT = STEP * ((1 << MW) - 1);
    localparam int unsigned CW    = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] secs;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [CW-1:0] target;

    always_comb begin
        target = CW'(STEP) * CW'(mult_i);
    end

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.secs = '0;
        end else if (run_i && tick_i && (st_q.secs != target)) begin
            st_d.secs = st_q.secs + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign expired_o = run_i && (st_q.secs == target);

endmodule

// File: rtl/spinup_ctrl.sv
module spinup_ctrl
    import spinup_pkg::*;
#(
    parameter int unsigned ID_W = SLOT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_a_i,
    input  logic            strap_b_i,
    input  logic [ID_W-1:0] slot_id_i,
    input  logic            start_cmd_i,
    input  logic            sec_tick_i,
    output logic            motor_en_o,
    output logic [1:0]      mode_o
);

    spin_cfg_t cfg;
    logic      stagger_run;
    logic      stagger_done;

    typedef struct packed {
        logic motor;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    spinup_cfg_latch #(.ID_W(ID_W)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_a_i (strap_a_i),
        .strap_b_i (strap_b_i),
        .slot_id_i (slot_id_i),
        .cfg_o     (cfg)
    );

    assign stagger_run = (cfg.policy == POLICY_STAGGERED);

    spinup_stagger_timer #(.STEP(STEP_SECS), .MW(MULT_W)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (stagger_run),
        .mult_i    (cfg.mult),
        .tick_i    (sec_tick_i),
        .expired_o (stagger_done)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.motor = 1'b0;
        end else if (!st_q.motor) begin
            unique case (cfg.policy)
                POLICY_AT_ONCE:   st_d.motor = 1'b1;
                POLICY_COMMAND:   st_d.motor = start_cmd_i;
                POLICY_STAGGERED: st_d.motor = stagger_done;
                POLICY_NEVER:     st_d.motor = 1'b0;
                default:          st_d.motor = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign motor_en_o = st_q.motor;
    assign mode_o     = cfg.policy;

endmodule

// File: rtl/spinup_ctrl_checker.sv
module spinup_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_cmd_i,
    input logic       motor_en_o,
    input logic [1:0] mode_o
);

    assert_motor_off_in_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !motor_en_o);

    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_o));

    assert_at_once_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00) && $past(rst_n) |-> motor_en_o);

    assert_cmd_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) && start_cmd_i |=> motor_en_o);

    assert_cmd_needed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(motor_en_o) && (mode_o == 2'b10) |-> $past(start_cmd_i));

    assert_never_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11) |-> !motor_en_o);

    assert_enable_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        motor_en_o |=> motor_en_o);

endmodule

bind spinup_ctrl spinup_ctrl_checker i_spinup_ctrl_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_cmd_i (start_cmd_i),
    .motor_en_o  (motor_en_o),
    .mode_o      (mode_o)
);

// File: tb/test_spinup_ctrl.sv
module test_spinup_ctrl;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_a = 1'b0;
    logic       strap_b = 1'b0;
    logic [6:0] slot_id = '0;
    logic       start_cmd = 1'b0;
    logic       sec_tick = 1'b0;
    logic       motor_en;
    logic [1:0] mode;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spinup_ctrl i_spinup_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_a_i   (strap_a),
        .strap_b_i   (strap_b),
        .slot_id_i   (slot_id),
        .start_cmd_i (start_cmd),
        .sec_tick_i  (sec_tick),
        .motor_en_o  (motor_en),
        .mode_o      (mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Reset with given straps; after release, the pins are scrambled (R1).
    task automatic do_reset(input logic b, input logic a, input logic [6:0] id);
        @(negedge clk);
        rst_n = 1'b0; strap_b = b; strap_a = a; slot_id = id;
        start_cmd = 1'b0; sec_tick = 1'b0;
        cycles(3);
        check("R1 motor low in reset", motor_en, 1'b0);
        rst_n = 1'b1;
        strap_b = ~b; strap_a = ~a; slot_id = ~id;
    endtask

    task automatic pulse_tick();
        sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic pulse_cmd();
        start_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0;
    endtask

    task automatic t_at_once();
        do_reset(1'b0, 1'b0, 7'h15);
        cycles(1);
        check("R3 motor on first cycle", motor_en, 1'b1);
        check("R2 mode at once", mode, 2'b00);
        cycles(5);
        check("R9 motor holds", motor_en, 1'b1);
        check("R1 straps ignored after reset", mode, 2'b00);
    endtask

    task automatic t_command();
        do_reset(1'b1, 1'b0, 7'h03);
        cycles(1);
        check("R2 mode command", mode, 2'b10);
        for (int i = 0; i < 40; i++) pulse_tick();
        check("R4 no start before cmd", motor_en, 1'b0);
        pulse_cmd();
        check("R4 start after cmd", motor_en, 1'b1);
        cycles(10);
        check("R9 motor holds after cmd", motor_en, 1'b1);
    endtask

    task automatic t_stagger(input logic [6:0] id, input bit send_cmd);
        int n;
        n = 12 * int'(id[2:0]);
        do_reset(1'b0, 1'b1, id);
        if (n == 0) begin
            cycles(1);
            check("R6 zero multiplier immediate", motor_en, 1'b1);
            check("R2 mode staggered", mode, 2'b01);
            return;
        end
        cycles(1);
        check("R2 mode staggered", mode, 2'b01);
        for (int i = 0; i < n - 1; i++) begin
            pulse_tick();
            @(negedge clk);
            if (send_cmd && i == 2) pulse_cmd();
        end
        check(send_cmd ? "R7 cmd ignored in stagger" : "R5 low before last tick", motor_en, 1'b0);
        pulse_tick();
        check("R5 low in cycle of last tick", motor_en, 1'b0);
        cycles(1);
        check("R5 high one cycle after last tick", motor_en, 1'b1);
        for (int i = 0; i < 5; i++) pulse_tick();
        check("R9 holds in stagger", motor_en, 1'b1);
    endtask

    task automatic t_never();
        do_reset(1'b1, 1'b1, 7'h00);
        cycles(1);
        check("R2 mode never", mode, 2'b11);
        for (int i = 0; i < 100; i++) begin
            if (i % 10 == 0) start_cmd = 1'b1;
            sec_tick = 1'b1;
            @(negedge clk);
            start_cmd = 1'b0; sec_tick = 1'b0;
        end
        check("R8 never starts", motor_en, 1'b0);
    endtask

    initial begin
        t_at_once();
        t_command();
        t_stagger(7'b1111_010, 1'b0);
        t_stagger(7'b0000_001, 1'b1);
        t_stagger(7'b1001_000, 1'b0);
        t_stagger(7'b0000_111, 1'b0);
        t_never();
        t_at_once();
        done = 1'b1;
    end

    initial begin
        int k;
        k = 0;
        while (!done && k < WATCHDOG) begin
            @(posedge clk);
            k++;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule